// File: doc/BRIEF.md
# Torus Nearest-Neighbour Shift Fabric

This block moves data words between the eight processing nodes of a SIMD array. The nodes form a 2x2x2 cube whose faces wrap around, so the array is a small three-dimensional torus. A central controller issues one shift command to all nodes at once. The command names one of six directions. Every node then sends its outgoing word one step that way and takes in the word that arrives from the opposite side. No node is addressed on its own, and there is no arbitration.

Each node is numbered `{z,y,x}`, with one bit per axis at the default size. Inputs and outputs are flattened buses, and node n uses bits `[n*WORD_W +: WORD_W]`. All eight received words are registered on the same clock edge. The registered words stay on the outputs until the next accepted shift. The cube edge can be widened through `AXIS_BITS`, and the wrap rules still apply.

Top module: `torus_shift_net`

## Requirements
- R1: While reset is active, and in the first cycle after it, every node output word is zero and `shift_done_o` is low.
- R2: A strobe on `shift_valid_i` with a legal direction code (0 to 5) raises `shift_done_o` in the next cycle. The flag lasts that one cycle only, unless a strobe arrives in the next cycle as well.
- R3: Direction codes 0 (toward -x) and 1 (toward +x) move words along x. At the default size, node n receives the word of node n XOR 1.
- R4: Direction codes 2 (toward -y) and 3 (toward +y) move words along y. At the default size, node n receives the word of node n XOR 2.
- R5: Direction codes 4 (toward -z) and 5 (toward +z) move words along z. At the default size, node n receives the word of node n XOR 4.
- R6: A strobe with code 6 or 7 is ignored. `shift_done_o` stays low and every output word keeps its value.
- R7: In a cycle with no strobe, every output word keeps its value, whatever is on the data inputs.
- R8: Strobes in consecutive cycles are each accepted. All eight node outputs change on the same edge, one cycle after each strobe.
- R9: At the default size, the two opposite directions on one axis give the same result, because the wrap neighbour and the direct neighbour are the same node.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_valid_i | input | 1 | Broadcast shift strobe, one cycle per command |
| shift_dir_i | input | 3 | Direction code: 0 -x, 1 +x, 2 -y, 3 +y, 4 -z, 5 +z |
| node_data_i | input | NODES*WORD_W | Outgoing word of each node, node n in slice n |
| node_data_o | output | NODES*WORD_W | Registered word received by each node |
| shift_done_o | output | 1 | High for one cycle after each accepted shift |

## Verification
The assertions assume that `shift_dir_i` and `node_data_i` are settled during any cycle in which `shift_valid_i` is high. They do not assume that the direction code is legal: an illegal code must leave the outputs untouched. The stimulus changes every input only at the falling clock edge. The random part mixes idle cycles, strobes with legal codes, strobes with codes 6 and 7, and runs of back-to-back strobes, so all of these cases reach the checked properties.

// File: rtl/torus_pkg.sv
package torus_pkg;

    typedef enum logic [2:0] {
        DIR_XM = 3'd0,
        DIR_XP = 3'd1,
        DIR_YM = 3'd2,
        DIR_YP = 3'd3,
        DIR_ZM = 3'd4,
        DIR_ZP = 3'd5
    } shift_dir_e;

    // Index of the node whose word lands in node n for a shift in direction d.
    function automatic int src_node(input int n, input int d, input int axis_bits);
        int s;
        int x;
        int y;
        int z;
        s = 1 << axis_bits;
        x = n % s;
        y = (n / s) % s;
        z = n / (s * s);
        case (d)
            0:       x = (x + 1) % s;
            1:       x = (x + s - 1) % s;
            2:       y = (y + 1) % s;
            3:       y = (y + s - 1) % s;
            4:       z = (z + 1) % s;
            5:       z = (z + s - 1) % s;
            default: x = x;
        endcase
        return (z * s + y) * s + x;
    endfunction

endpackage

// File: rtl/torus_dir_decode.sv
module torus_dir_decode
    import torus_pkg::*;
(
    input  logic       valid_i,
    input  logic [2:0] code_i,
    output logic       fire_o,
    output shift_dir_e dir_o
);

    always_comb begin
        fire_o = valid_i && (code_i <= 3'd5);
        dir_o  = shift_dir_e'(code_i);
    end

endmodule

// File: rtl/torus_crossbar.sv
module torus_crossbar
    import torus_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int AXIS_BITS = 1,
    localparam int NODES    = 1 << (3 * AXIS_BITS),
    localparam int BUS_W    = NODES * WORD_W
) (
    input  logic [BUS_W-1:0] data_i,
    input  shift_dir_e       dir_i,
    output logic [BUS_W-1:0] data_o
);

    for (genvar n = 0; n < NODES; n++) begin : g_node
        localparam int SRC_XM = src_node(n, 0, AXIS_BITS);
        localparam int SRC_XP = src_node(n, 1, AXIS_BITS);
        localparam int SRC_YM = src_node(n, 2, AXIS_BITS);
        localparam int SRC_YP = src_node(n, 3, AXIS_BITS);
        localparam int SRC_ZM = src_node(n, 4, AXIS_BITS);
        localparam int SRC_ZP = src_node(n, 5, AXIS_BITS);

        always_comb begin
            case (dir_i)
                DIR_XM:  data_o[n*WORD_W +: WORD_W] = data_i[SRC_XM*WORD_W +: WORD_W];
                DIR_XP:  data_o[n*WORD_W +: WORD_W] = data_i[SRC_XP*WORD_W +: WORD_W];
                DIR_YM:  data_o[n*WORD_W +: WORD_W] = data_i[SRC_YM*WORD_W +: WORD_W];
                DIR_YP:  data_o[n*WORD_W +: WORD_W] = data_i[SRC_YP*WORD_W +: WORD_W];
                DIR_ZM:  data_o[n*WORD_W +: WORD_W] = data_i[SRC_ZM*WORD_W +: WORD_W];
                DIR_ZP:  data_o[n*WORD_W +: WORD_W] = data_i[SRC_ZP*WORD_W +: WORD_W];
                default: data_o[n*WORD_W +: WORD_W] = data_i[n*WORD_W +: WORD_W];
            endcase
        end
    end

endmodule

// File: rtl/torus_shift_net.sv
module torus_shift_net
    import torus_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int AXIS_BITS = 1,
    localparam int NODES    = 1 << (3 * AXIS_BITS),
    localparam int BUS_W    = NODES * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_valid_i,
    input  logic [2:0]       shift_dir_i,
    input  logic [BUS_W-1:0] node_data_i,
    output logic [BUS_W-1:0] node_data_o,
    output logic             shift_done_o
);

    typedef struct packed {
        logic [BUS_W-1:0] data;
        logic             done;
    } state_t;

    state_t           st_d;
    state_t           st_q;
    logic             fire;
    shift_dir_e       dir;
    logic [BUS_W-1:0] moved;

    torus_dir_decode u_decode (
        .valid_i (shift_valid_i),
        .code_i  (shift_dir_i),
        .fire_o  (fire),
        .dir_o   (dir)
    );

    torus_crossbar #(
        .WORD_W    (WORD_W),
        .AXIS_BITS (AXIS_BITS)
    ) u_xbar (
        .data_i (node_data_i),
        .dir_i  (dir),
        .data_o (moved)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = fire;
        if (fire) begin
            st_d.data = moved;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign node_data_o  = st_q.data;
    assign shift_done_o = st_q.done;

    AST_DONE_AFTER_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_valid_i && shift_dir_i <= 3'd5) |=> shift_done_o); // R2

    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_done_o |-> ($past(shift_valid_i) && $past(shift_dir_i) <= 3'd5)); // R2

    AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_valid_i && shift_dir_i > 3'd5) |=> (!shift_done_o && $stable(node_data_o))); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_done_o |-> $stable(node_data_o)); // R7

    AST_ALL_NODES_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_valid_i && shift_dir_i <= 3'd5) |=> (node_data_o[WORD_W-1:0] ==
            $past(node_data_i[src_node(0, int'(shift_dir_i), AXIS_BITS)*WORD_W +: WORD_W]))); // R8

endmodule

// File: tb/torus_shift_net_tb.sv
`timescale 1ns/1ps
module torus_shift_net_tb;

    localparam int W     = 16;
    localparam int NODES = 8;
    localparam int NW    = NODES * W;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          shift_valid_i;
    logic [2:0]    shift_dir_i;
    logic [NW-1:0] node_data_i;
    logic [NW-1:0] node_data_o;
    logic          shift_done_o;

    int checks = 0;
    int errors = 0;

    logic [NW-1:0] exp_data;
    logic          exp_done;

    always #10 clk = ~clk;

    torus_shift_net #(.WORD_W(W), .AXIS_BITS(1)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .shift_valid_i (shift_valid_i),
        .shift_dir_i   (shift_dir_i),
        .node_data_i   (node_data_i),
        .node_data_o   (node_data_o),
        .shift_done_o  (shift_done_o)
    );

    function automatic logic [NW-1:0] model(input logic [NW-1:0] d, input logic [2:0] code);
        logic [NW-1:0] r;
        int mask;
        mask = (code < 3'd2) ? 1 : (code < 3'd4) ? 2 : 4;
        for (int n = 0; n < NODES; n++) begin
            r[n*W +: W] = d[(n ^ mask)*W +: W];
        end
        return r;
    endfunction

    function automatic string tag_for(input logic v, input logic [2:0] code);
        if (!v) return "R7";
        if (code > 3'd5) return "R6";
        if (code < 3'd2) return "R3";
        if (code < 3'd4) return "R4";
        return "R5";
    endfunction

    function automatic logic [NW-1:0] rand_bus();
        logic [NW-1:0] r;
        for (int n = 0; n < NODES; n++) begin
            r[n*W +: W] = W'($urandom);
        end
        return r;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [NW-1:0] act,
                         input logic [NW-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Called at a falling edge: drive, pass one rising edge, check at next falling edge.
    task automatic step(input logic v, input logic [2:0] code, input logic [NW-1:0] d,
                        input string tag);
        shift_valid_i = v;
        shift_dir_i   = code;
        node_data_i   = d;
        @(posedge clk);
        if (v && code <= 3'd5) begin
            exp_data = model(d, code);
            exp_done = 1'b1;
        end else begin
            exp_done = 1'b0;
        end
        @(negedge clk);
        check(shift_done_o == exp_done, (v && code <= 3'd5) ? "R2" : tag,
              NW'(shift_done_o), NW'(exp_done));
        check(node_data_o == exp_data, tag, node_data_o, exp_data);
    endtask

    initial begin
        #(20ns * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [NW-1:0] pat;
        logic [NW-1:0] first;
        void'($urandom(32'h5eed_1234));
        rst_n         = 1'b0;
        shift_valid_i = 1'b1;
        shift_dir_i   = 3'd1;
        node_data_i   = '1;
        exp_data      = '0;
        exp_done      = 1'b0;
        repeat (3) @(negedge clk);
        check(node_data_o == '0, "R1", node_data_o, '0);
        check(shift_done_o == 1'b0, "R1", NW'(shift_done_o), '0);
        shift_valid_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(node_data_o == '0 && !shift_done_o, "R1", node_data_o, '0);

        // Directed: every legal direction, distinct node words, then an idle cycle
        for (int d = 0; d < 6; d++) begin
            for (int n = 0; n < NODES; n++) pat[n*W +: W] = W'(16'h1000 * (d + 1) + n);
            step(1'b1, 3'(d), pat, tag_for(1'b1, 3'(d)));
            step(1'b0, 3'(d), rand_bus(), "R7");
        end

        // Illegal codes 6 and 7 leave state alone (R6)
        step(1'b1, 3'd6, rand_bus(), "R6");
        step(1'b1, 3'd7, rand_bus(), "R6");

        // Opposite directions on one axis agree at size 2 (R9)
        for (int a = 0; a < 3; a++) begin
            pat = rand_bus();
            step(1'b1, 3'(2 * a), pat, "R9");
            first = node_data_o;
            step(1'b1, 3'(2 * a + 1), pat, "R9");
            check(node_data_o == first, "R9", node_data_o, first);
        end

        // Back-to-back strobes (R8)
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 3'(i % 6), rand_bus(), "R8");
        end

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            logic v;
            logic [2:0] c;
            v = ($urandom % 4) != 0;
            c = ($urandom % 8 == 0) ? 3'(6 + $urandom % 2) : 3'($urandom % 6);
            step(v, c, rand_bus(), tag_for(v, c));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule